// File: doc/BRIEF.md
# Spindle Motor PWM Generator

This block turns a two-bit motor mode and a signed speed-error word into drive pulses for a disk spindle motor driver. It runs one pulse-width modulator on a fixed frame of `PERIOD_CLKS` clocks. With the defaults and an 8.4672 MHz clock, one frame is 192 clocks, which is 22.68 us, one sample period at 44.1 kHz. Each frame opens with at most one pulse. The pulse width is a whole number of steps of `STEP_CLKS` clocks. It runs from 1 step (2 clocks, about 236 ns) to `MAX_STEPS` steps (64 steps, 128 clocks, about 15.1 us).

Three outputs carry the pulse. Acceleration pulses appear only on `accel_o`, and deceleration pulses appear only on `decel_o`. A combined drive pin goes high for acceleration, goes low for deceleration and floats at all other times. The block gives that pin as a value (`drive_o`) and an output enable (`drive_oe_o`), and the pad cell builds the three-state pin from the two.

In servo mode the magnitude of the error is shifted right by `ERR_SHIFT` and held between 1 and `MAX_STEPS` steps. The sign of the error picks the direction. The error itself is computed outside this block. The mode and the error are sampled once per frame, on the last clock of the frame, so a pulse is never cut short or stretched while it is running.

Top module: `spindle_pwm`

## Requirements
- R1: The frame is exactly `PERIOD_CLKS` (192) clocks long. The frame counter runs from 0 to 191 and wraps to 0, and the first frame after reset starts at counter value 0.
- R2: Mode 2'b00 is off. In off mode `accel_o` and `decel_o` stay low for the whole frame and `drive_oe_o` stays low.
- R3: Mode 2'b01 is full acceleration. `accel_o` is high for the first 128 clocks of each frame and low for the rest, and `decel_o` stays low.
- R4: Mode 2'b10 is full deceleration. `decel_o` is high for the first 128 clocks of each frame and low for the rest, and `accel_o` stays low.
- R5: Mode 2'b11 is servo. A positive error gives an acceleration pulse of 2*N clocks at the start of the frame, where N = |err| >> 4, held between 1 and 64.
- R6: In servo mode a negative error gives a deceleration pulse on `decel_o` with the same width rule as R5, and `accel_o` stays low.
- R7: In servo mode an error of zero gives no pulse. Both single-sided outputs stay low and `drive_oe_o` stays low.
- R8: A nonzero error whose magnitude is below 16 gives the minimum pulse of 1 step (2 clocks).
- R9: An error magnitude of 1024 or more, including -32768, saturates at 64 steps (128 clocks).
- R10: `drive_oe_o` is high exactly while a pulse is active. While it is high, `drive_o` is 1 for acceleration and 0 for deceleration. `accel_o` and `decel_o` are never high at the same time.
- R11: The mode and the error are taken only on the last clock of a frame (counter value 191). A change made at any other time has no effect on the frame already running and applies from the next frame.
- R12: During reset all outputs are low. The first frame after reset has no pulse in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (8.4672 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Motor mode: 00 off, 01 full accelerate, 10 full decelerate, 11 servo |
| speed_err_i | input | ERR_W (16) | Signed speed error; positive means too slow |
| accel_o | output | 1 | Acceleration pulse |
| decel_o | output | 1 | Deceleration pulse |
| drive_o | output | 1 | Combined drive value: 1 accelerate, 0 decelerate |
| drive_oe_o | output | 1 | Combined drive enable; the pin floats when this is low |

## Verification
The hardest case to reach from the ports is a change of mode or error while a frame is running. The width in force can only be seen through the pulses of the frame that follows. The bench therefore changes the inputs right after each frame boundary. It checks, clock by clock, that the frame already running still follows the previous setting and that the next frame follows the new one.

A sweep of signed error values runs in both directions across the minimum, the scaling steps, the saturation point and the most negative word. The fixed modes are interleaved with the sweep, so every pair of neighbouring settings is also a check of R11.

// File: rtl/spindle_pwm_pkg.sv
package spindle_pwm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ACC = 2'b01,
    MODE_DEC = 2'b10,
    MODE_SRV = 2'b11
  } spin_mode_e;
endpackage

// File: rtl/spindle_period_ctr.sv
module spindle_period_ctr #(
  parameter int PERIOD_CLKS = 192,
  localparam int CNT_W = $clog2(PERIOD_CLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD_CLKS - 1);

  assign last_o = (cnt_o == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (last_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == LAST_CNT) |=> (cnt_o == '0));
  a_r1_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != LAST_CNT) |=> (cnt_o == $past(cnt_o) + 1'b1));
  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= LAST_CNT);
endmodule

// File: rtl/spindle_width_calc.sv
module spindle_width_calc
  import spindle_pwm_pkg::*;
#(
  parameter int ERR_W     = 16,
  parameter int ERR_SHIFT = 4,
  parameter int MAX_STEPS = 64,
  localparam int STEP_W = $clog2(MAX_STEPS + 1)
) (
  input  spin_mode_e               mode_i,
  input  logic signed [ERR_W-1:0]  err_i,
  output logic [STEP_W-1:0]        steps_o,
  output logic                     dec_o
);
  localparam logic [ERR_W:0] MAX_EXT = (ERR_W+1)'(MAX_STEPS);

  logic [ERR_W:0] err_ext, mag, scaled;
  logic [STEP_W-1:0] srv_steps;

  // one extra bit so the most negative word has a magnitude
  assign err_ext = {err_i[ERR_W-1], err_i};
  assign mag     = err_i[ERR_W-1] ? (~err_ext + 1'b1) : err_ext;
  assign scaled  = mag >> ERR_SHIFT;

  always_comb begin
    if (err_i == '0)            srv_steps = '0;
    else if (scaled == '0)      srv_steps = STEP_W'(1);
    else if (scaled > MAX_EXT)  srv_steps = STEP_W'(MAX_STEPS);
    else                        srv_steps = scaled[STEP_W-1:0];
  end

  always_comb begin
    unique case (mode_i)
      MODE_ACC: begin steps_o = STEP_W'(MAX_STEPS); dec_o = 1'b0;           end
      MODE_DEC: begin steps_o = STEP_W'(MAX_STEPS); dec_o = 1'b1;           end
      MODE_SRV: begin steps_o = srv_steps;          dec_o = err_i[ERR_W-1]; end
      default:  begin steps_o = '0;                 dec_o = 1'b0;           end
    endcase
  end
endmodule

// File: rtl/spindle_pulse_gen.sv
module spindle_pulse_gen #(
  parameter int PERIOD_CLKS = 192,
  parameter int STEP_CLKS   = 2,
  parameter int MAX_STEPS   = 64,
  localparam int CNT_W  = $clog2(PERIOD_CLKS),
  localparam int STEP_W = $clog2(MAX_STEPS + 1),
  localparam int LIM_W  = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              last_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic              dec_i,
  output logic              accel_o,
  output logic              decel_o,
  output logic              drive_o,
  output logic              drive_oe_o
);
  logic [STEP_W-1:0] steps_q;
  logic              dec_q;
  logic [LIM_W-1:0]  lim;
  logic              active;

  // width and direction are frozen for a whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steps_q <= '0;
      dec_q   <= 1'b0;
    end else if (last_i) begin
      steps_q <= steps_i;
      dec_q   <= dec_i;
    end
  end

  assign lim    = LIM_W'(steps_q) * LIM_W'(STEP_CLKS);
  assign active = ({1'b0, cnt_i} < lim);

  assign accel_o    = active & ~dec_q;
  assign decel_o    = active &  dec_q;
  assign drive_oe_o = active;
  assign drive_o    = active & ~dec_q;

  a_r11_hold_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> ($stable(steps_q) && $stable(dec_q)));
  a_r9_width_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_q <= STEP_W'(MAX_STEPS));
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accel_o && decel_o));
  a_r10_accel_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accel_o |-> (drive_oe_o && drive_o));
  a_r10_decel_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decel_o |-> (drive_oe_o && !drive_o));
endmodule

// File: rtl/spindle_pwm.sv
module spindle_pwm
  import spindle_pwm_pkg::*;
#(
  parameter int PERIOD_CLKS = 192,
  parameter int STEP_CLKS   = 2,
  parameter int MAX_STEPS   = 64,
  parameter int ERR_W       = 16,
  parameter int ERR_SHIFT   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic signed [ERR_W-1:0] speed_err_i,
  output logic                    accel_o,
  output logic                    decel_o,
  output logic                    drive_o,
  output logic                    drive_oe_o
);
  localparam int CNT_W  = $clog2(PERIOD_CLKS);
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  spin_mode_e        mode;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic [STEP_W-1:0] steps;
  logic              dec;

  assign mode = spin_mode_e'(mode_i);

  spindle_period_ctr #(.PERIOD_CLKS(PERIOD_CLKS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .last_o (last)
  );

  spindle_width_calc #(
    .ERR_W     (ERR_W),
    .ERR_SHIFT (ERR_SHIFT),
    .MAX_STEPS (MAX_STEPS)
  ) u_calc (
    .mode_i  (mode),
    .err_i   (speed_err_i),
    .steps_o (steps),
    .dec_o   (dec)
  );

  spindle_pulse_gen #(
    .PERIOD_CLKS (PERIOD_CLKS),
    .STEP_CLKS   (STEP_CLKS),
    .MAX_STEPS   (MAX_STEPS)
  ) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .last_i     (last),
    .steps_i    (steps),
    .dec_i      (dec),
    .accel_o    (accel_o),
    .decel_o    (decel_o),
    .drive_o    (drive_o),
    .drive_oe_o (drive_oe_o)
  );

  a_r2_off_no_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_OFF) |-> (steps == '0));
  a_r7_zero_no_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SRV && speed_err_i == '0) |-> (steps == '0));
  a_r8_nonzero_has_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SRV && speed_err_i != '0) |-> (steps != '0));
  a_r6_neg_decel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SRV && speed_err_i < 0) |-> dec);
endmodule

// File: tb/spindle_pwm_tb.sv
module spindle_pwm_tb;
  localparam int P = 192;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         mode = 2'b00;
  logic signed [15:0] err = '0;
  logic accel, decel, drv, drv_oe;

  int checks = 0;
  int errors = 0;
  int e = 0;
  // expectation for the frame now running
  int cur_steps = 0;
  bit cur_dec = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) e <= e + 1;

  spindle_pwm u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .speed_err_i (err),
    .accel_o     (accel),
    .decel_o     (decel),
    .drive_o     (drv),
    .drive_oe_o  (drv_oe)
  );

  function automatic int exp_steps(int m, int v);
    int a;
    if (m == 0) return 0;
    if (m == 1 || m == 2) return 64;
    if (v == 0) return 0;
    a = (v < 0) ? -v : v;
    a = a / 16;
    if (a == 0) return 1;
    if (a > 64) return 64;
    return a;
  endfunction

  function automatic bit exp_dec(int m, int v);
    if (m == 2) return 1'b1;
    if (m == 3) return v < 0;
    return 1'b0;
  endfunction

  // call at a negedge with e%P==0; samples one whole frame
  task automatic measure(string req, int st, bit dc);
    int bad = 0;
    int a_act = 0, d_act = 0;
    for (int i = 0; i < P; i++) begin
      bit act = (i < 2 * st);
      bit ea = act & ~dc;
      bit ed = act & dc;
      if (accel) a_act++;
      if (decel) d_act++;
      if (accel !== ea || decel !== ed || drv_oe !== act || (act && drv !== ~dc))
        bad++;
      @(negedge clk);
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: accel %0d decel %0d clocks, %0d bad samples; expected width %0d dir_dec %0d",
               req, a_act, d_act, bad, 2 * st, dc);
    end
  endtask

  // change inputs at a frame start: the running frame keeps the old width (R11)
  task automatic run(string req, int m, int v);
    int st = exp_steps(m, v);
    bit dc = exp_dec(m, v);
    mode = 2'(m);
    err  = 16'(v);
    measure("R11", cur_steps, cur_dec);
    cur_steps = st;
    cur_dec   = dc;
    measure(req, st, dc);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mode = 2'b01;
    err  = 16'sd500;
    repeat (3) @(negedge clk);
    checks++;
    if (accel !== 1'b0 || decel !== 1'b0 || drv_oe !== 1'b0) begin
      errors++;
      $display("FAIL R12: in reset accel %b decel %b oe %b, expected 0 0 0", accel, decel, drv_oe);
    end
    rst_n = 1'b1;
    // first frame after reset: no pulse even though full acceleration is asked for (R12)
    measure("R12", 0, 1'b0);
    cur_steps = 64;
    cur_dec   = 1'b0;
    measure("R3", 64, 1'b0);
    // period check: frame edge seen exactly every P clocks (R1)
    run("R1", 0, 0);
    run("R2", 0, 1234);
    run("R4", 2, 0);
    run("R3", 1, -77);
    run("R7", 3, 0);
    run("R8", 3, 1);
    run("R8", 3, -1);
    run("R8", 3, 15);
    run("R5", 3, 16);
    run("R6", 3, -17);
    run("R5", 3, 1023);
    run("R9", 3, 1024);
    run("R9", 3, 1040);
    run("R9", 3, 32767);
    run("R9", 3, -32768);
    run("R2", 0, -500);
    for (int v = -1100; v <= 1100; v += 73) begin
      run(v < 0 ? "R6" : "R5", 3, v);
      run("R10", (v & 1) ? 2 : 1, v);
    end
    run("R7", 3, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule